// File: doc/BRIEF.md
# Partitioned Byte-by-Coefficient Multiplier

This block is a SIMD multiplier for pixel processing. In each lane an unsigned 8-bit pixel byte is multiplied by a signed 16-bit coefficient. The lane keeps the middle 16 bits of the product and rounds them up when the bit just below that slice is set. Two 64-bit operands, `op_a` and `op_b`, feed the lanes. A 3-bit variant code chooses which bytes and coefficients go to each lane, and how the lane results are laid out in the 64-bit result.

The seven variants cover three cases. The first is a lane-wise product of four bytes and four coefficients. The second broadcasts one coefficient to all four bytes. The third takes the upper or the lower byte of each 16-bit lane of `op_a`. There is also a widened form that computes two lanes only and places each 16-bit result 7 bits up inside a 32-bit field. The block has one register stage. A valid input is captured on a clock edge, and `out_valid` goes high for one cycle after that edge. The result stays unchanged until the next valid input.

Top module: `pmul8x16`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `bad_variant` and `result` are all 0 until the first valid input.
- R2: A lane result is floor((pixel × coefficient + 128) / 256) taken modulo 2^16, with the pixel unsigned 8-bit and the coefficient signed 16-bit. Example: pixel 0x01 × coefficient 0xFF80 gives 0x0000 (wraps), and 0x80 × 0x0001 gives 0x0001.
- R3: Code 0 (lane-wise): pixel i = `op_a[8i+7:8i]` and coefficient i = `op_b[16i+15:16i]`, for i = 0..3. Lane result i goes to `result[16i+15:16i]`. `op_a[63:32]` has no effect.
- R4: Codes 1 and 2 (broadcast): pixel i = `op_a[8i+7:8i]`. All lanes use the coefficient `op_b[31:16]` (code 1) or `op_b[15:0]` (code 2). The output layout is the one of R3.
- R5: Codes 3 and 4 (byte pick): pixel i = `op_a[16i+15:16i+8]` (code 3) or `op_a[16i+7:16i]` (code 4). Coefficient i = `op_b[16i+15:16i]`. The output layout is the one of R3.
- R6: Codes 5 and 6 (widened): only lanes i = 0 and 1 are computed. Their pixel is the upper byte (code 5) or the lower byte (code 6) of `op_a[16i+15:16i]`, and their coefficient is `op_b[16i+15:16i]`. Lane result i goes to `result[32i+22:32i+7]`, and every other result bit is 0.
- R7: Code 7 is reserved. A valid input with code 7 gives `result` = 0 and `bad_variant` = 1. Codes 0 to 6 give `bad_variant` = 0.
- R8: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` = 1, and is 0 otherwise. Back-to-back valid inputs each produce their own result in consecutive cycles.
- R9: While `in_valid` = 0, `result` and `bad_variant` keep their values whatever `variant`, `op_a` and `op_b` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and variant are presented this cycle |
| variant | input | 3 | Variant code 0..6, code 7 reserved |
| op_a | input | 64 | Pixel operand |
| op_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| result | output | 64 | Registered lane results |
| bad_variant | output | 1 | The last captured variant was reserved |

## Verification
Every result, `bad_variant` value and `out_valid` pulse is due exactly one clock edge after the cycle in which `in_valid` was high. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so each read lands half a period after the edge that registered the data. For the back-to-back and hold scenarios the bench reads the outputs before it drives new inputs on the same falling edge. This ties each expected value to a single capture edge, including the cycles in which nothing may change.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  localparam int BYTE_W = 8;
  localparam int COEF_W = 16;
  localparam int PROD_W = BYTE_W + COEF_W;

  typedef enum logic [2:0] {
    PM_LANEWISE = 3'd0,
    PM_BCAST_HI = 3'd1,
    PM_BCAST_LO = 3'd2,
    PM_HI_BYTE  = 3'd3,
    PM_LO_BYTE  = 3'd4,
    PM_WIDE_HI  = 3'd5,
    PM_WIDE_LO  = 3'd6,
    PM_RESERVED = 3'd7
  } pmul_mode_e;

  // Unsigned pixel times signed coefficient, middle slice with round-up.
  function automatic logic [COEF_W-1:0] scale_round(
    input logic        [BYTE_W-1:0] pix,
    input logic signed [COEF_W-1:0] coef
  );
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    prod = PROD_W'($signed({1'b0, pix})) * PROD_W'(coef);
    rnd  = prod + PROD_W'(1 << (BYTE_W - 1));
    return COEF_W'(rnd >>> BYTE_W);
  endfunction

  function automatic logic mode_is_wide(input pmul_mode_e m);
    return (m == PM_WIDE_HI) || (m == PM_WIDE_LO);
  endfunction

  function automatic logic mode_is_reserved(input pmul_mode_e m);
    return m == PM_RESERVED;
  endfunction

endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIX_W = BYTE_W,
  parameter int CF_W  = COEF_W
) (
  input  pmul_mode_e                      mode,
  input  logic [LANES*CF_W-1:0]           op_a,
  input  logic [LANES*CF_W-1:0]           op_b,
  output logic [LANES-1:0][PIX_W-1:0]     pix,
  output logic [LANES-1:0][CF_W-1:0]      coef
);

  localparam int WIDE_LANES = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IN_WIDE = (i < WIDE_LANES);
    logic [PIX_W-1:0] packed_byte;
    logic [PIX_W-1:0] hi_byte;
    logic [PIX_W-1:0] lo_byte;
    logic [CF_W-1:0]  own_coef;

    assign packed_byte = op_a[i*PIX_W +: PIX_W];
    assign hi_byte     = op_a[i*CF_W + PIX_W +: PIX_W];
    assign lo_byte     = op_a[i*CF_W +: PIX_W];
    assign own_coef    = op_b[i*CF_W +: CF_W];

    always_comb begin
      pix[i]  = '0;
      coef[i] = '0;
      unique case (mode)
        PM_LANEWISE: begin pix[i] = packed_byte; coef[i] = own_coef;          end
        PM_BCAST_HI: begin pix[i] = packed_byte; coef[i] = op_b[CF_W +: CF_W]; end
        PM_BCAST_LO: begin pix[i] = packed_byte; coef[i] = op_b[0 +: CF_W];    end
        PM_HI_BYTE:  begin pix[i] = hi_byte;     coef[i] = own_coef;          end
        PM_LO_BYTE:  begin pix[i] = lo_byte;     coef[i] = own_coef;          end
        PM_WIDE_HI: begin
          if (IN_WIDE) begin pix[i] = hi_byte; coef[i] = own_coef; end
        end
        PM_WIDE_LO: begin
          if (IN_WIDE) begin pix[i] = lo_byte; coef[i] = own_coef; end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
#(
  parameter int PIX_W = BYTE_W,
  parameter int CF_W  = COEF_W
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [CF_W-1:0]  coef,
  output logic [CF_W-1:0]  lane_out
);

  assign lane_out = scale_round(pix, $signed(coef));

endmodule

// File: rtl/pmul_place.sv
module pmul_place
  import pmul_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int CF_W       = COEF_W,
  parameter int WIDE_SHIFT = 7
) (
  input  pmul_mode_e                  mode,
  input  logic [LANES-1:0][CF_W-1:0]  lanes,
  output logic [LANES*CF_W-1:0]       placed,
  output logic                        reserved
);

  localparam int OP_W       = LANES * CF_W;
  localparam int FIELD_W    = 2 * CF_W;
  localparam int WIDE_LANES = LANES / 2;

  logic [OP_W-1:0] narrow_v;
  logic [OP_W-1:0] wide_v;

  assign narrow_v = lanes;

  for (genvar i = 0; i < WIDE_LANES; i++) begin : g_wide
    assign wide_v[i*FIELD_W +: FIELD_W] = FIELD_W'(lanes[i]) << WIDE_SHIFT;
  end

  assign reserved = mode_is_reserved(mode);

  always_comb begin
    if (reserved)                 placed = '0;
    else if (mode_is_wide(mode))  placed = wide_v;
    else                          placed = narrow_v;
  end

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
  import pmul_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int PIX_W      = BYTE_W,
  parameter int CF_W       = COEF_W,
  parameter int WIDE_SHIFT = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [2:0]             variant,
  input  logic [LANES*CF_W-1:0]  op_a,
  input  logic [LANES*CF_W-1:0]  op_b,
  output logic                   out_valid,
  output logic [LANES*CF_W-1:0]  result,
  output logic                   bad_variant
);

  localparam int OP_W = LANES * CF_W;

  pmul_mode_e                 mode;
  logic [LANES-1:0][PIX_W-1:0] pix;
  logic [LANES-1:0][CF_W-1:0]  coef;
  logic [LANES-1:0][CF_W-1:0]  lane_res;
  logic [OP_W-1:0]             next_result;
  logic                        mode_bad;
  logic                        capture;

  assign mode    = pmul_mode_e'(variant);
  assign capture = in_valid;

  pmul_opsel #(.LANES(LANES), .PIX_W(PIX_W), .CF_W(CF_W)) u_opsel (
    .mode (mode),
    .op_a (op_a),
    .op_b (op_b),
    .pix  (pix),
    .coef (coef)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmul_lane #(.PIX_W(PIX_W), .CF_W(CF_W)) u_lane (
      .pix      (pix[i]),
      .coef     (coef[i]),
      .lane_out (lane_res[i])
    );
  end

  pmul_place #(.LANES(LANES), .CF_W(CF_W), .WIDE_SHIFT(WIDE_SHIFT)) u_place (
    .mode     (mode),
    .lanes    (lane_res),
    .placed   (next_result),
    .reserved (mode_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      bad_variant <= 1'b0;
    end else begin
      out_valid <= capture;
      if (capture) begin
        result      <= next_result;
        bad_variant <= mode_bad;
      end
    end
  end

endmodule

// File: rtl/pmul8x16_checker.sv
module pmul8x16_checker #(
  parameter int LANES      = 4,
  parameter int CF_W       = 16,
  parameter int WIDE_SHIFT = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [2:0]            variant,
  input logic                  out_valid,
  input logic [LANES*CF_W-1:0] result,
  input logic                  bad_variant
);

  localparam int OP_W    = LANES * CF_W;
  localparam int FIELD_W = 2 * CF_W;

  function automatic logic [OP_W-1:0] gap_mask();
    logic [OP_W-1:0] m;
    m = '1;
    for (int i = 0; i < LANES / 2; i++)
      for (int k = 0; k < CF_W; k++)
        m[i*FIELD_W + WIDE_SHIFT + k] = 1'b0;
    return m;
  endfunction

  localparam logic [OP_W-1:0] GAPS = gap_mask();

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(bad_variant)));

  a_r7_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && variant == 3'd7) |=> (bad_variant && result == '0));

  a_r7_legal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && variant != 3'd7) |=> !bad_variant);

  a_r6_wide_gaps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (variant == 3'd5 || variant == 3'd6)) |=> ((result & GAPS) == '0));

endmodule

bind pmul8x16 pmul8x16_checker #(
  .LANES(LANES), .CF_W(CF_W), .WIDE_SHIFT(WIDE_SHIFT)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .variant     (variant),
  .out_valid   (out_valid),
  .result      (result),
  .bad_variant (bad_variant)
);

// File: tb/test_pmul8x16.sv
module test_pmul8x16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  variant = 3'd0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        bad_variant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmul8x16 i_pmul8x16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .variant(variant),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
    .bad_variant(bad_variant)
  );

  // reference lane: slice 23:8 of the 32-bit product, plus bit 7
  function automatic logic [15:0] ref_lane(input int pix, input int coef);
    int p;
    logic [31:0] pu;
    p  = pix * coef;
    pu = p;
    return pu[23:8] + {15'd0, pu[7]};
  endfunction

  function automatic logic [64:0] model(input logic [2:0] m, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    if (m == 3'd7) return {1'b1, 64'd0};
    for (int i = 0; i < 4; i++) begin
      int px;
      int cf;
      cf = $signed(b[16*i +: 16]);
      case (m)
        3'd0: px = a[8*i +: 8];
        3'd1: begin px = a[8*i +: 8]; cf = $signed(b[31:16]); end
        3'd2: begin px = a[8*i +: 8]; cf = $signed(b[15:0]);  end
        3'd3, 3'd5: px = a[16*i+8 +: 8];
        default: px = a[16*i +: 8];
      endcase
      if (m == 3'd5 || m == 3'd6) begin
        if (i < 2) r[32*i+7 +: 16] = ref_lane(px, cf);
      end else begin
        r[16*i +: 16] = ref_lane(px, cf);
      end
    end
    return {1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one valid cycle, then the outputs are read one edge later
  task automatic issue(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; variant = m; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic issue_and_check(input string tag, input logic [2:0] m,
                                 input logic [63:0] a, input logic [63:0] b);
    logic [64:0] e;
    e = model(m, a, b);
    issue(m, a, b);
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " result"}, result, e[63:0]);
    check({tag, " bad"}, 64'(bad_variant), 64'(e[64]));
  endtask

  task automatic t_reset;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset bad", 64'(bad_variant), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", 64'(out_valid), 64'd0);
    check("R1 after release result", result, 64'd0);
  endtask

  task automatic t_lane_math;
    // lanes: 0x10*0x0100, 0x01*0xFF80 (wrap), 0xFF*0x7FFF, 0x80*0x0001
    issue(3'd0, 64'hDEAD_BEEF_80FF_0110, 64'h0001_7FFF_FF80_0100);
    check("R2 hand values", result, 64'h0001_7F7F_0000_0010);
    issue(3'd0, 64'h0000_0000_FF80_7F01, 64'h8000_8000_8001_FFFF);
    check("R2 negative coef", result, model(3'd0, 64'h0000_0000_FF80_7F01,
                                            64'h8000_8000_8001_FFFF)[63:0]);
  endtask

  task automatic t_lanewise;
    issue_and_check("R3 lanewise", 3'd0, 64'h0123_4567_89AB_CDEF, 64'h1234_F00D_8000_7FFF);
    issue(3'd0, 64'hFFFF_FFFF_89AB_CDEF, 64'h1234_F00D_8000_7FFF);
    check("R3 upper op_a ignored", result,
          model(3'd0, 64'h0123_4567_89AB_CDEF, 64'h1234_F00D_8000_7FFF)[63:0]);
  endtask

  task automatic t_broadcast;
    issue_and_check("R4 bcast hi", 3'd1, 64'h0000_0000_FF80_4001, 64'h1111_2222_8000_0200);
    issue_and_check("R4 bcast lo", 3'd2, 64'h0000_0000_FF80_4001, 64'h1111_2222_8000_0200);
  endtask

  task automatic t_byte_pick;
    issue_and_check("R5 hi byte", 3'd3, 64'hFF01_80C0_7F02_10FE, 64'h7FFF_8000_0100_FF00);
    issue_and_check("R5 lo byte", 3'd4, 64'hFF01_80C0_7F02_10FE, 64'h7FFF_8000_0100_FF00);
  endtask

  task automatic t_wide;
    issue_and_check("R6 wide hi", 3'd5, 64'hAAAA_BBBB_FF01_8002, 64'hCCCC_DDDD_7FFF_8000);
    issue_and_check("R6 wide lo", 3'd6, 64'hAAAA_BBBB_FF01_8002, 64'hCCCC_DDDD_7FFF_8000);
    issue(3'd5, 64'h0000_0000_FF00_FF00, 64'h0000_0000_7FFF_7FFF);
    check("R6 wide placement", result, 64'h0000_0000_003F_BF80 | 64'h003F_BF80_0000_0000 >> 0
          & 64'h0000_0000_0000_0000 | (64'h0000_0000_003F_BF80 << 32));
  endtask

  task automatic t_reserved;
    issue_and_check("R7 reserved", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
    issue_and_check("R7 legal clears", 3'd0, 64'h0000_0000_0101_0101, 64'h0100_0100_0100_0100);
  endtask

  task automatic t_timing;
    logic [64:0] e1, e2;
    e1 = model(3'd0, 64'h0000_0000_0102_0304, 64'h0100_0200_0300_0400);
    e2 = model(3'd4, 64'h00FF_00FE_00FD_00FC, 64'hFF00_FE00_FD00_FC00);
    @(negedge clk);
    in_valid = 1'b1; variant = 3'd0;
    op_a = 64'h0000_0000_0102_0304; op_b = 64'h0100_0200_0300_0400;
    @(negedge clk);
    check("R8 first valid", 64'(out_valid), 64'd1);
    check("R8 first result", result, e1[63:0]);
    variant = 3'd4; op_a = 64'h00FF_00FE_00FD_00FC; op_b = 64'hFF00_FE00_FD00_FC00;
    @(negedge clk);
    check("R8 second valid", 64'(out_valid), 64'd1);
    check("R8 second result", result, e2[63:0]);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 valid drops", 64'(out_valid), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    issue(3'd1, 64'h0000_0000_1234_5678, 64'h0000_0000_7000_0000);
    keep = result;
    for (int k = 0; k < 3; k++) begin
      variant = 3'(7 - k); op_a = {2{32'hA5A5_0000 + 32'(k)}}; op_b = ~op_a;
      @(negedge clk);
      check("R9 result held", result, keep);
      check("R9 bad held", 64'(bad_variant), 64'd0);
      check("R8 idle valid low", 64'(out_valid), 64'd0);
    end
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 40; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      issue_and_check("R2 R3 R4 R5 R6 R7 sweep", 3'(n % 8), a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_lane_math;
    t_lanewise;
    t_broadcast;
    t_byte_pick;
    t_wide;
    t_reserved;
    t_timing;
    t_hold;
    t_sweep;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule